// File: doc/BRIEF.md
# Sprite DMA Window Generator

This block keeps the horizontal beam position of a raster video chipset and raises a flag that allows sprite fetches during a fixed stretch of every line. The position register steps forward on each pixel-clock enable, returns to zero after a programmable last position, and marks each new line with a one-cycle strobe.

The window edges are not found with full-width equality compares. The counter only counts up within a line. So the first value at which every set bit of a target position is also set in the counter is the target itself. Each edge detector therefore ANDs only the counter bits that are set in its target: bits 2 and 4 for the opening edge at 20, and bits 2, 8 and 9 for the closing edge at 772. That is five inputs in total.

Later positions that carry the same bit pattern (21 to 23, 788 and others) would fire those detectors again. A pair of per-line guard flags stops that, and both flags clear when the line wraps.

Top module: `sprite_dma_window`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `hpos` = 0, `spr_dma_en` = 0 and `line_start` = 0.
- R2: A clock edge with `pix_en` high and `hpos` not equal to `line_last` increments `hpos` by one. A clock edge with `pix_en` low leaves `hpos` unchanged.
- R3: A clock edge with `pix_en` high and `hpos` equal to `line_last` sets `hpos` to 0. `line_start` is high for exactly the cycle after each such wrap and low at all other times.
- R4: `spr_dma_en` goes high on the cycle after `hpos` reads 20, unless that same edge is a line wrap.
- R5: `spr_dma_en` goes low on the cycle after `hpos` reads 772.
- R6: After the window has closed in a line, later positions whose bits 4 and 2 are both set (for example 788) do not reopen it. The flag stays low until the line wraps.
- R7: A line wrap forces `spr_dma_en` low on the following cycle. This covers lines whose last position is below 772, and a wrap taken while `hpos` reads 20.
- R8: When `line_last` is below 20, `spr_dma_en` never goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel-clock enable; one position step per enabled cycle |
| line_last | input | 10 | Last position of a line; hold it stable while out of reset |
| hpos | output | 10 | Current horizontal position |
| spr_dma_en | output | 1 | Registered sprite fetch window flag |
| line_start | output | 1 | One-cycle strobe on the cycle after a line wrap |

## Verification
On every cycle the assertions check the counter's step and hold behaviour and the wrap-to-zero with its strobe. They also check that the window rises only after position 20, falls after 772 and is low after any wrap. Only the bench's sweeps can show the absence of spurious reopenings across whole lines, because it sets the sparse decode beside a model built from full 10-bit equality. Those sweeps use several line lengths: full length, exactly 772, shorter than 772, and below 20. They run with a steady pixel enable and with a gapped one.

// File: rtl/sprwin_pkg.sv
package sprwin_pkg;

    // Guard and output state of the window for the current line.
    typedef struct packed {
        logic opened;   // open edge already taken this line
        logic closed;   // close edge already taken this line
        logic active;   // window flag driven to the port
    } win_state_t;

    // True when every bit set in mask is also set in pos.
    // On an up-only counter this first holds at pos == mask.
    function automatic logic bits_cover(input logic [31:0] pos, input logic [31:0] mask);
        return (pos & mask) == mask;
    endfunction

endpackage

// File: rtl/sprwin_hcount.sv
module sprwin_hcount #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pix_en,
    input  logic [W-1:0] line_last,
    output logic [W-1:0] pos,
    output logic         wrap,
    output logic         strobe
);
    assign wrap = pix_en && (pos == line_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos    <= '0;
            strobe <= 1'b0;
        end else begin
            strobe <= wrap;
            if (wrap)
                pos <= '0;
            else if (pix_en)
                pos <= pos + 1'b1;
        end
    end
endmodule

// File: rtl/sprwin_edge.sv
module sprwin_edge #(
    parameter int W      = 10,
    parameter int TARGET = 20
) (
    input  logic [W-1:0] pos,
    input  logic         armed,
    output logic         hit
);
    import sprwin_pkg::*;

    localparam logic [W-1:0] MASK = W'(TARGET);

    // Only the bits set in MASK reach the AND; the rest drop out.
    assign hit = armed && bits_cover(32'(pos), 32'(MASK));
endmodule

// File: rtl/sprwin_ctrl.sv
module sprwin_ctrl (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wrap,
    input  logic                   open_hit,
    input  logic                   close_hit,
    output sprwin_pkg::win_state_t st
);
    import sprwin_pkg::*;

    win_state_t st_nx;

    always_comb begin
        st_nx = st;
        if (wrap) begin
            st_nx = '0;
        end else begin
            if (open_hit) begin
                st_nx.opened = 1'b1;
                st_nx.active = 1'b1;
            end
            if (close_hit) begin
                st_nx.closed = 1'b1;
                st_nx.active = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nx;
    end
endmodule

// File: rtl/sprite_dma_window.sv
module sprite_dma_window #(
    parameter int POS_W    = 10,
    parameter int OPEN_AT  = 20,
    parameter int CLOSE_AT = 772
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_en,
    input  logic [POS_W-1:0] line_last,
    output logic [POS_W-1:0] hpos,
    output logic             spr_dma_en,
    output logic             line_start
);
    import sprwin_pkg::*;

    logic       wrap;
    logic       open_hit;
    logic       close_hit;
    win_state_t st;

    sprwin_hcount #(.W(POS_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .pix_en    (pix_en),
        .line_last (line_last),
        .pos       (hpos),
        .wrap      (wrap),
        .strobe    (line_start)
    );

    sprwin_edge #(.W(POS_W), .TARGET(OPEN_AT)) u_open (
        .pos   (hpos),
        .armed (!st.opened),
        .hit   (open_hit)
    );

    sprwin_edge #(.W(POS_W), .TARGET(CLOSE_AT)) u_close (
        .pos   (hpos),
        .armed (st.opened && !st.closed),
        .hit   (close_hit)
    );

    sprwin_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wrap      (wrap),
        .open_hit  (open_hit),
        .close_hit (close_hit),
        .st        (st)
    );

    assign spr_dma_en = st.active;
endmodule

// File: rtl/sprite_dma_window_chk.sv
module sprite_dma_window_chk #(
    parameter int POS_W    = 10,
    parameter int OPEN_AT  = 20,
    parameter int CLOSE_AT = 772
) (
    input logic             clk,
    input logic             rst,
    input logic             pix_en,
    input logic [POS_W-1:0] line_last,
    input logic [POS_W-1:0] hpos,
    input logic             spr_dma_en,
    input logic             line_start
);
    localparam logic [POS_W-1:0] OPEN_POS  = POS_W'(OPEN_AT);
    localparam logic [POS_W-1:0] CLOSE_POS = POS_W'(CLOSE_AT);

    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hpos != line_last) |=> hpos == $past(hpos) + 1'b1);

    p_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !pix_en |=> $stable(hpos));

    p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hpos == line_last) |=> (hpos == '0 && line_start));

    p_strobe_zero_r3: assert property (@(posedge clk) disable iff (rst)
        line_start |-> hpos == '0);

    p_open_r4: assert property (@(posedge clk) disable iff (rst)
        (hpos == OPEN_POS && !(pix_en && line_last == OPEN_POS)) |=> spr_dma_en);

    p_close_r5: assert property (@(posedge clk) disable iff (rst)
        hpos == CLOSE_POS |=> !spr_dma_en);

    p_rise_only_at_open_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(spr_dma_en) |-> $past(hpos) == OPEN_POS);

    p_wrap_low_r7: assert property (@(posedge clk) disable iff (rst)
        (pix_en && hpos == line_last) |=> !spr_dma_en);

    p_short_line_r8: assert property (@(posedge clk) disable iff (rst)
        line_last < OPEN_POS |-> !$rose(spr_dma_en));
endmodule

bind sprite_dma_window sprite_dma_window_chk #(
    .POS_W(POS_W), .OPEN_AT(OPEN_AT), .CLOSE_AT(CLOSE_AT)
) u_chk (
    .clk(clk), .rst(rst), .pix_en(pix_en), .line_last(line_last),
    .hpos(hpos), .spr_dma_en(spr_dma_en), .line_start(line_start)
);

// File: tb/sprite_dma_window_test.sv
`timescale 1ns/1ps
module sprite_dma_window_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pix_en = 1'b0;
    logic [9:0] line_last = 10'd1023;
    logic [9:0] hpos;
    logic       spr_dma_en;
    logic       line_start;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // reference state, full-width compares
    int mcnt = 0;
    bit mwin = 0;
    bit mstb = 0;

    always #5 clk = ~clk;

    sprite_dma_window uut (
        .clk(clk), .rst(rst), .pix_en(pix_en), .line_last(line_last),
        .hpos(hpos), .spr_dma_en(spr_dma_en), .line_start(line_start)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d (line_last=%0d)", req, what, act, exp, line_last);
        end
    endtask

    function automatic string win_tag(input int oldc, input bit wr);
        if (wr) return "R7";
        if (line_last < 10'd20) return "R8";
        if (oldc == 20) return "R4";
        if (oldc == 772) return "R5";
        if (oldc > 772) return "R6";
        return "R4";
    endfunction

    task automatic step(input bit pe);
        int  oldc;
        bit  wr;
        string t;
        pix_en = pe;
        @(posedge clk);
        oldc = mcnt;
        wr   = pe && (mcnt == int'(line_last));
        t    = win_tag(oldc, wr);
        if (wr)               mwin = 0;
        else if (mcnt == 20)  mwin = 1;
        else if (mcnt == 772) mwin = 0;
        mstb = wr;
        if (wr)      mcnt = 0;
        else if (pe) mcnt = (mcnt + 1) % 1024;
        #2;
        check("R2", int'(hpos), mcnt, "hpos");
        check("R3", int'(line_start), int'(mstb), "line_start");
        check(t, int'(spr_dma_en), int'(mwin), "spr_dma_en");
    endtask

    task automatic run_len(input int last, input int lines, input bit gappy);
        int n;
        rst = 1'b1;
        line_last = 10'(last);
        pix_en = 1'b1;
        repeat (2) @(posedge clk);
        #2;
        check("R1", int'(hpos), 0, "hpos after reset");
        check("R1", int'(spr_dma_en), 0, "window after reset");
        check("R1", int'(line_start), 0, "strobe after reset");
        rst = 1'b0;
        mcnt = 0; mwin = 0; mstb = 0;
        n = lines * (last + 1) * (gappy ? 2 : 1) + 3;
        for (int i = 0; i < n; i++)
            step(gappy ? (($urandom % 4) != 0) : 1'b1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        #1;
        run_len(1023, 2, 0);   // full line: R4 R5 R6 (788 etc. follow close)
        run_len(799, 2, 1);    // gapped enable, R2 hold
        run_len(772, 2, 0);    // wrap coincides with close position
        run_len(780, 1, 1);
        run_len(500, 2, 0);    // shorter than 772: R7 closes at wrap
        run_len(500, 1, 1);
        run_len(20, 3, 0);     // wrap while hpos reads 20: R7
        run_len(21, 3, 1);
        run_len(10, 4, 0);     // below 20: R8
        run_len(0, 3, 1);      // wrap on every enabled cycle
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule